// File: doc/BRIEF.md
# Pulse-Stream Signed Magnitude Extractor

This block converts the one-bit output of a sigma-delta sensor readout into signed binary numbers. The incoming bit is brought into the system clock domain by a short synchronizer chain. Two flag registers follow the chain. One holds the present polarity and the other holds the polarity of one cycle earlier. A signed counter tracks each stretch of constant polarity. It steps upward while the level is 1 and downward while it is 0. The count therefore grows with the pulse width measured in system clock cycles, and its sign gives the direction of the sensed acceleration.

When the two flags disagree, a polarity change has reached the flags. In that cycle the counter's value is copied into a holding register and the counter restarts at zero. Each copy raises a new-data flag. A processor polls this flag, reads the holding register and then pulses a clear request. The processor never sees the live counter.

Top module: `pulse_run_extractor`

## Requirements
- R1: While reset is high, and on the first edge after it is released, the held value reads 0 and the new-data flag reads 0.
- R2: A run of L clock cycles at input level 1 is captured as +(L-1), provided that value is in range. A level of 1 means positive acceleration.
- R3: A run of L clock cycles at input level 0 is captured as -(L-1), provided that value is in range. A level of 0 means negative acceleration.
- R4: Take an input level change driven between two clock edges. The held value and the new-data flag change on the fourth rising edge after that change and not before.
- R5: Between captures the held value stays constant. This holds whether or not clear requests arrive.
- R6: Every capture sets the new-data flag to 1.
- R7: A clear request with no capture in the same cycle clears the new-data flag on that edge. The held value is left unchanged.
- R8: When a clear request and a capture fall on the same edge, the capture wins and the flag remains 1.
- R9: An up-count saturates at 2^(W-1)-1 and does not wrap. A long 1-run is captured as exactly that value.
- R10: A down-count saturates at -2^(W-1) and does not wrap. A long 0-run is captured as exactly that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 1 | Asynchronous polarity bitstream (1 = positive) |
| clr_req | input | 1 | Processor request to clear the new-data flag |
| held_val | output | W | Last captured run count, two's complement |
| new_data | output | 1 | Set on capture, cleared by clr_req |

## Verification
A level change driven between edges passes through two synchronizer flops and then the present and previous flags. It is captured on the fourth rising edge. The bench drives inputs on falling edges. At the third falling edge of a new run it checks that the old value and old flag are still present. At the fourth falling edge it checks that the new value and a set flag have appeared. Clear requests are held across exactly one rising edge, and the flag is checked at the next falling edge. A request placed on the capture edge checks the collision rule.

// File: rtl/run_pkg.sv
package run_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD    = 2'd0,
    STEP_UP      = 2'd1,
    STEP_DOWN    = 2'd2,
    STEP_RESTART = 2'd3
  } step_e;
endpackage

// File: rtl/run_polarity_sync.sv
module run_polarity_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  output logic pol_cur,
  output logic pol_prev
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= bit_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], bit_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_cur  <= 1'b0;
      pol_prev <= 1'b0;
    end else begin
      pol_cur  <= chain[STAGES-1];
      pol_prev <= pol_cur;
    end
  end

  AST_PREV_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pol_prev == $past(pol_cur)); // R4
endmodule

// File: rtl/run_counter.sv
module run_counter
  import run_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  step_e               step,
  output logic signed [W-1:0] count
);
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0] nxt;

  always_comb begin
    nxt = count;
    unique case (step)
      STEP_RESTART: nxt = '0;
      STEP_UP:      if (count != MAXV) nxt = count + 1'b1;
      STEP_DOWN:    if (count != MINV) nxt = count - 1'b1;
      default:      nxt = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= nxt;
  end

  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_UP && count == MAXV) |=> count == MAXV); // R9
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_DOWN && count == MINV) |=> count == MINV); // R10
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_RESTART) |=> count == '0); // R2
  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_UP && count != MAXV) |=> count == $past(count) + 1'b1); // R2
endmodule

// File: rtl/run_capture.sv
module run_capture #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic signed [W-1:0] din,
  input  logic                clr,
  output logic signed [W-1:0] held,
  output logic                flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
      flag <= 1'b0;
    end else begin
      if (load) held <= din;
      if (load)     flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  AST_FLAG_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> flag); // R6
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(held)); // R5
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (clr && !load) |=> !flag); // R7
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (clr && load) |=> flag); // R8
endmodule

// File: rtl/pulse_run_extractor.sv
module pulse_run_extractor
  import run_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pulse_in,
  input  logic         clr_req,
  output logic [W-1:0] held_val,
  output logic         new_data
);
  logic                pol_cur;
  logic                pol_prev;
  logic                edge_seen;
  step_e               step;
  logic signed [W-1:0] run_count;
  logic signed [W-1:0] held_s;

  run_polarity_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .bit_in(pulse_in),
    .pol_cur(pol_cur), .pol_prev(pol_prev)
  );

  assign edge_seen = pol_cur ^ pol_prev;

  always_comb begin
    if (edge_seen)    step = STEP_RESTART;
    else if (pol_cur) step = STEP_UP;
    else              step = STEP_DOWN;
  end

  run_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .count(run_count)
  );

  run_capture #(.W(W)) u_cap (
    .clk(clk), .rst(rst), .load(edge_seen), .din(run_count),
    .clr(clr_req), .held(held_s), .flag(new_data)
  );

  assign held_val = held_s;

  AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (rst)
    (edge_seen && run_count != '0) |=> held_s[W-1] == !$past(pol_prev)); // R2 R3
endmodule

// File: tb/tb_pulse_run_extractor.sv
`timescale 1ns/1ps
module tb_pulse_run_extractor;
  localparam int W = 6;
  localparam int MAXI = (1 << (W-1)) - 1;
  localparam int MINI = -(1 << (W-1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pulse_in = 1'b0;
  logic clr_req = 1'b0;
  logic [W-1:0] held_val;
  logic new_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit have_prev = 1'b0;
  int held_old = 0;
  int exp_prev = 0;
  string tag_prev = "R2";
  bit flag_exp = 1'b0;

  always #2 clk = ~clk;

  pulse_run_extractor #(.W(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .pulse_in(pulse_in), .clr_req(clr_req),
    .held_val(held_val), .new_data(new_data)
  );

  function automatic int held_int();
    return int'($signed(held_val));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run(input logic v, input int len, input int mode);
    int e;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      pulse_in = v;
      if (i == 3 && have_prev) begin
        chk("R4 value not early", held_int(), held_old);
        chk("R4 flag not early", int'(new_data), int'(flag_exp));
      end
      if (i == 3 && mode == 2) clr_req = 1'b1;
      if (i == 4) begin
        clr_req = 1'b0;
        if (have_prev) begin
          chk(tag_prev, held_int(), exp_prev);
          chk(mode == 2 ? "R8 collision" : "R6 flag set", int'(new_data), 1);
        end
        held_old = held_int();
        flag_exp = 1'b1;
      end
      if (i == 6 && mode == 1) clr_req = 1'b1;
      if (i == 7 && mode == 1) begin
        clr_req = 1'b0;
        chk("R7 flag cleared", int'(new_data), 0);
        chk("R5 value kept after clear", held_int(), held_old);
        flag_exp = 1'b0;
      end
    end
    e = v ? (len - 1) : -(len - 1);
    if (e > MAXI) begin e = MAXI; tag_prev = "R9"; end
    else if (e < MINI) begin e = MINI; tag_prev = "R10"; end
    else tag_prev = v ? "R2" : "R3";
    exp_prev = e;
    have_prev = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset value", held_int(), 0);
    chk("R1 reset flag", int'(new_data), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 value after release", held_int(), 0);
    chk("R1 flag after release", int'(new_data), 0);
    run(1'b1, 10, 1);
    have_prev = 1'b0;
    run(1'b0, 10, 1);
    for (int len = 8; len <= 40; len++) begin
      run(1'b1, len, (len == 20) ? 2 : 1);
      run(1'b0, len, 1);
    end
    run(1'b1, 10, 1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule